// File: doc/BRIEF.md
# Serial Result Output and Clock-Pattern Mode Controller

This block is the digital side of a converter that has no programmable registers. Finished conversion results reach it as a word plus a one-cycle strobe from the conversion engine. It presents each result on a single open-collector-style output line that does double duty. The line first drops low to announce that a result is waiting. It then serves as the serial data line, advanced by rising edges of a serial clock supplied by the host.

The same serial clock is also the only command channel. The number of edges the host gives, and how long it holds the clock high, select an offset calibration, a standby state, or standby followed by a calibration on wake-up.

The serial clock is asynchronous to the system clock. It is passed through a two-stage synchronizer, and its edges are detected in the system clock domain. Every duration is a parameter counted in system clock cycles: the update window before new data, the calibration length at each speed, and the standby activation time. An active-low power-down input clears all state and keeps the block idle.

Top module: `sclk_serial_ctl`

## Requirements
- R1: While `pdwn_n` is low, `dout_rdy` is 1 and both `cal_active` and `standby` are 0. After release, `dout_rdy` stays 1 until a result strobe arrives.
- R2: A `res_strobe` accepted in the idle or data state latches `res_word`. `dout_rdy` then stays 1 for `UPD_CYC` cycles (the update window) and afterwards goes to 0 to signal ready.
- R3: After the n-th synchronized rising edge of `sclk_in`, for n = 1 to `DATA_W`, `dout_rdy` shows bit `DATA_W`-n of the latched word (the most significant bit comes first).
- R4: After exactly `DATA_W` rising edges, `dout_rdy` keeps showing bit 0. Rising edges `DATA_W`+1 up to `DATA_W`+5 drive it to 1.
- R5: A new strobe that arrives while a result is presented replaces that result, even if it has been read only in part. `dout_rdy` returns to 1 for the update window, and the next read starts again at the new most significant bit.
- R6: A falling edge of `sclk_in` that follows exactly `DATA_W`+6 rising edges starts a calibration. `cal_active` is then 1 for `CAL_FAST` cycles when `speed_fast`=1, or for `CAL_SLOW` cycles when `speed_fast`=0. After that the block is idle and waits for the next strobe.
- R7: During calibration `dout_rdy` is 1, and result strobes and serial clock edges are ignored: the calibration length is unchanged and no data is presented afterwards.
- R8: Holding `sclk_in` high for `STBY_CYC` cycles while a result is presented, at any point of a readback, sets `standby` to 1 with `dout_rdy` at 1. Strobes are ignored in standby. Driving `sclk_in` low clears `standby` and returns the block to idle.
- R9: If standby was entered with exactly `DATA_W`+5 rising edges counted, waking from it starts a calibration as in R6 instead of going idle.
- R10: Serial clock edges received while no result is presented have no effect. A later result is read from its most significant bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pdwn_n | input | 1 | Active-low power-down; asynchronous clear of all state |
| sclk_in | input | 1 | Host serial clock, asynchronous |
| speed_fast | input | 1 | 1 selects the short calibration length, 0 the long one |
| res_word | input | DATA_W | Conversion result, two's complement |
| res_strobe | input | 1 | One-cycle pulse: `res_word` holds a new result |
| dout_rdy | output | 1 | Combined ready flag (low) and serial data line |
| cal_active | output | 1 | High while an offset calibration runs |
| standby | output | 1 | High while the analog section is held in standby |

## Verification
The hardest states to reach are the two calibration entries. One needs exactly twenty-six full clock pulses followed by a falling edge. The other needs exactly twenty-five pulses, with the last one held high past the standby activation time. Each edge must survive the synchronizer, so the bench drives the serial clock with pulses of at least three system cycles per phase. Directed sequences build those exact counts, at both speed settings, and bound the calibration window from both sides. Randomly seeded reads of random length, each cut short by an overwriting strobe, cover the partial-read and overwrite paths.

// File: rtl/sclk_serial_pkg.sv
package sclk_serial_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_UPDATE = 3'd1,
    ST_DATA   = 3'd2,
    ST_CAL    = 3'd3,
    ST_STBY   = 3'd4
  } ctl_state_e;

  // calibration length picked by the speed select
  function automatic int unsigned cal_length(input logic fast,
                                             input int unsigned fast_len,
                                             input int unsigned slow_len);
    return fast ? fast_len : slow_len;
  endfunction

endpackage

// File: rtl/sclk_edge_sync.sv
module sclk_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], async_in};
  end

  assign lvl  = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~chain[STAGES];
  assign fall = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/hold_counter.sv
module hold_counter #(
  parameter int LIMIT = 16,
  localparam int W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic reached
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!enable)        cnt <= '0;
    else if (cnt != W'(LIMIT)) cnt <= cnt + 1'b1;
  end

  assign reached = enable && (cnt == W'(LIMIT));
endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expire
);
  logic [W-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          left <= '0;
    else if (load)       left <= load_val;
    else if (left != '0) left <= left - 1'b1;
  end

  assign expire = (left == W'(1));
endmodule

// File: rtl/sclk_serial_ctl.sv
module sclk_serial_ctl
  import sclk_serial_pkg::*;
#(
  parameter int DATA_W   = 20,
  parameter int UPD_CYC  = 480,
  parameter int CAL_FAST = 497_808,
  parameter int CAL_SLOW = 3_937_088,
  parameter int STBY_CYC = 98,
  parameter int SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              pdwn_n,
  input  logic              sclk_in,
  input  logic              speed_fast,
  input  logic [DATA_W-1:0] res_word,
  input  logic              res_strobe,
  output logic              dout_rdy,
  output logic              cal_active,
  output logic              standby
);
  localparam int TRAIL     = 4;
  localparam int STBY_CAL  = DATA_W + TRAIL + 1;
  localparam int CAL_EDGE  = DATA_W + TRAIL + 2;
  localparam int CNT_W     = $clog2(CAL_EDGE + 2);
  localparam int CNT_MAX   = (1 << CNT_W) - 1;
  localparam int LONG_CAL  = (CAL_FAST > CAL_SLOW) ? CAL_FAST : CAL_SLOW;
  localparam int TMR_MAX   = (LONG_CAL > UPD_CYC) ? LONG_CAL : UPD_CYC;
  localparam int TMR_W     = $clog2(TMR_MAX + 1);

  // pin value while a result is presented, given edges seen so far
  function automatic logic pin_level(input logic [CNT_W-1:0] n,
                                     input logic [DATA_W-1:0] w);
    int k;
    k = int'(n);
    if (k == 0)      return 1'b0;
    if (k <= DATA_W) return w[DATA_W - k];
    return 1'b1;
  endfunction

  // named internal events, brought out for the checker
  logic sclk_lvl, sclk_rise, sclk_fall;
  logic hold_done, tmr_expire;

  ctl_state_e        state, nxt_state;
  logic [CNT_W-1:0]  edge_cnt;
  logic [DATA_W-1:0] word_q;
  logic              cal_on_wake;

  logic             tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic             take_word, cnt_clr, cnt_inc, set_wake_cal;

  sclk_edge_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk      (clk),
    .rst_n    (pdwn_n),
    .async_in (sclk_in),
    .lvl      (sclk_lvl),
    .rise     (sclk_rise),
    .fall     (sclk_fall)
  );

  hold_counter #(.LIMIT(STBY_CYC)) u_hold (
    .clk     (clk),
    .rst_n   (pdwn_n),
    .enable  (sclk_lvl && (state == ST_DATA)),
    .reached (hold_done)
  );

  phase_timer #(.W(TMR_W)) u_tmr (
    .clk      (clk),
    .rst_n    (pdwn_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expire   (tmr_expire)
  );

  always_comb begin
    nxt_state    = state;
    tmr_load     = 1'b0;
    tmr_val      = TMR_W'(UPD_CYC);
    take_word    = 1'b0;
    cnt_clr      = 1'b0;
    cnt_inc      = 1'b0;
    set_wake_cal = 1'b0;
    case (state)
      ST_IDLE: begin
        if (res_strobe) begin
          nxt_state = ST_UPDATE;
          tmr_load  = 1'b1;
          take_word = 1'b1;
        end
      end
      ST_UPDATE: begin
        if (res_strobe) begin
          tmr_load  = 1'b1;
          take_word = 1'b1;
        end else if (tmr_expire) begin
          nxt_state = ST_DATA;
          cnt_clr   = 1'b1;
        end
      end
      ST_DATA: begin
        if (res_strobe) begin
          nxt_state = ST_UPDATE;
          tmr_load  = 1'b1;
          take_word = 1'b1;
        end else if (hold_done) begin
          nxt_state    = ST_STBY;
          set_wake_cal = (edge_cnt == CNT_W'(STBY_CAL));
        end else if (sclk_fall && (edge_cnt == CNT_W'(CAL_EDGE))) begin
          nxt_state = ST_CAL;
          tmr_load  = 1'b1;
          tmr_val   = TMR_W'(cal_length(speed_fast, CAL_FAST, CAL_SLOW));
        end else if (sclk_rise && (edge_cnt != CNT_W'(CNT_MAX))) begin
          cnt_inc = 1'b1;
        end
      end
      ST_CAL: begin
        if (tmr_expire) nxt_state = ST_IDLE;
      end
      ST_STBY: begin
        if (!sclk_lvl) begin
          if (cal_on_wake) begin
            nxt_state = ST_CAL;
            tmr_load  = 1'b1;
            tmr_val   = TMR_W'(cal_length(speed_fast, CAL_FAST, CAL_SLOW));
          end else begin
            nxt_state = ST_IDLE;
          end
        end
      end
      default: nxt_state = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge pdwn_n) begin
    if (!pdwn_n) begin
      state       <= ST_IDLE;
      edge_cnt    <= '0;
      word_q      <= '0;
      cal_on_wake <= 1'b0;
    end else begin
      state <= nxt_state;
      if (take_word) word_q <= res_word;
      if (cnt_clr)      edge_cnt <= '0;
      else if (cnt_inc) edge_cnt <= edge_cnt + 1'b1;
      if (nxt_state == ST_STBY && state == ST_DATA) cal_on_wake <= set_wake_cal;
    end
  end

  assign dout_rdy   = (state == ST_DATA) ? pin_level(edge_cnt, word_q) : 1'b1;
  assign cal_active = (state == ST_CAL);
  assign standby    = (state == ST_STBY);
endmodule

// File: rtl/sclk_serial_ctl_chk.sv
module sclk_serial_ctl_chk (
  input logic clk,
  input logic pdwn_n,
  input logic dout_rdy,
  input logic cal_active,
  input logic standby,
  input logic sclk_lvl,
  input logic fall_evt
);
  // R1: power-down forces the quiet state
  p_pdwn_quiet_r1: assert property (@(posedge clk)
    !pdwn_n |-> (dout_rdy && !cal_active && !standby));

  // R6: calibration only starts from a falling edge or a standby wake
  p_cal_trigger_r6: assert property (@(posedge clk) disable iff (!pdwn_n)
    $rose(cal_active) |-> ($past(fall_evt) || $past(standby)));

  // R6: calibration and standby never overlap
  p_cal_stby_excl_r6: assert property (@(posedge clk) disable iff (!pdwn_n)
    !(cal_active && standby));

  // R7: pin idles high during calibration
  p_cal_pin_high_r7: assert property (@(posedge clk) disable iff (!pdwn_n)
    cal_active |-> dout_rdy);

  // R8: pin idles high in standby
  p_stby_pin_high_r8: assert property (@(posedge clk) disable iff (!pdwn_n)
    standby |-> dout_rdy);

  // R8: standby is entered only with the clock held high
  p_stby_entry_r8: assert property (@(posedge clk) disable iff (!pdwn_n)
    $rose(standby) |-> $past(sclk_lvl));

  // R8: standby is left only with the clock low
  p_stby_exit_r8: assert property (@(posedge clk) disable iff (!pdwn_n)
    $fell(standby) |-> !$past(sclk_lvl));
endmodule

bind sclk_serial_ctl sclk_serial_ctl_chk u_chk (
  .clk        (clk),
  .pdwn_n     (pdwn_n),
  .dout_rdy   (dout_rdy),
  .cal_active (cal_active),
  .standby    (standby),
  .sclk_lvl   (sclk_lvl),
  .fall_evt   (sclk_fall)
);

// File: tb/tb_sclk_serial_ctl.sv
module tb_sclk_serial_ctl;
  localparam int DW    = 20;
  localparam int UPD   = 4;
  localparam int CFAST = 40;
  localparam int CSLOW = 120;
  localparam int STBY  = 16;

  logic          clk = 1'b0;
  logic          pdwn_n = 1'b0;
  logic          sclk_in = 1'b0;
  logic          speed_fast = 1'b1;
  logic [DW-1:0] res_word = '0;
  logic          res_strobe = 1'b0;
  logic          dout_rdy, cal_active, standby;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  sclk_serial_ctl #(
    .DATA_W(DW), .UPD_CYC(UPD), .CAL_FAST(CFAST), .CAL_SLOW(CSLOW), .STBY_CYC(STBY)
  ) dut (
    .clk(clk), .pdwn_n(pdwn_n), .sclk_in(sclk_in), .speed_fast(speed_fast),
    .res_word(res_word), .res_strobe(res_strobe),
    .dout_rdy(dout_rdy), .cal_active(cal_active), .standby(standby)
  );

  // expected pin level after k rising edges
  function automatic logic exp_pin(input logic [DW-1:0] w, input int k);
    if (k == 0)  return 1'b0;
    if (k <= DW) return w[DW-k];
    return 1'b1;
  endfunction

  task automatic chk(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic pulse();
    sclk_in = 1'b1;
    repeat (3) @(negedge clk);
    sclk_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic strobe(input logic [DW-1:0] w);
    res_word   = w;
    res_strobe = 1'b1;
    @(negedge clk);
    res_strobe = 1'b0;
  endtask

  // strobe, confirm update window, then ready low
  task automatic deliver(input logic [DW-1:0] w, input string tag);
    strobe(w);
    chk(dout_rdy, 1'b1, {tag, " update window high"});
    repeat (UPD + 1) @(negedge clk);
    chk(dout_rdy, 1'b0, {tag, " ready low"});
  endtask

  task automatic read_bits(input logic [DW-1:0] w, input int from, input int n);
    for (int k = from + 1; k <= from + n; k++) begin
      pulse();
      chk(dout_rdy, exp_pin(w, k), (k <= DW) ? "R3 data bit" : "R4 trailing one");
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] w;
    int n;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk(dout_rdy, 1'b1, "R1 pin in power-down");
    chk(cal_active, 1'b0, "R1 cal in power-down");
    chk(standby, 1'b0, "R1 standby in power-down");
    pdwn_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(dout_rdy, 1'b1, "R1 pin idle after release");

    // R10: edges with nothing presented are ignored
    pulse(); pulse(); pulse();
    chk(dout_rdy, 1'b1, "R10 idle edges");
    w = 20'hA5C3E;
    deliver(w, "R2");
    read_bits(w, 0, 4);

    // R5: overwrite mid-read, then read new word from MSB
    w = 20'h3B7D1;
    deliver(w, "R5");
    read_bits(w, 0, 6);

    // R4: full read with bit0 = 0, hold, then trailing ones
    w = 20'hFFFFE;
    deliver(w, "R4");
    read_bits(w, 0, DW);
    repeat (6) @(negedge clk);
    chk(dout_rdy, 1'b0, "R4 holds last bit");
    read_bits(w, DW, 5);

    // random reads of random length, each overwritten by the next
    for (int it = 0; it < 30; it++) begin
      w = DW'($urandom);
      n = $urandom_range(0, 24);
      deliver(w, "R5 random");
      read_bits(w, 0, n);
    end

    // R6: calibration at fast speed, with R7 ignored activity inside it
    speed_fast = 1'b1;
    w = 20'h12345;
    deliver(w, "R6");
    read_bits(w, 0, 26);
    chk(cal_active, 1'b1, "R6 cal starts fast");
    chk(dout_rdy, 1'b1, "R7 pin high in cal");
    strobe(20'h0F0F0);
    pulse(); pulse();
    chk(dout_rdy, 1'b1, "R7 pin high after ignored activity");
    repeat (CFAST - 3 - 13) @(negedge clk);
    chk(cal_active, 1'b1, "R6 cal still active near fast end");
    repeat (5) @(negedge clk);
    chk(cal_active, 1'b0, "R6 cal done fast");
    chk(dout_rdy, 1'b1, "R7 no data after cal");

    // R6: slow speed calibration length
    speed_fast = 1'b0;
    w = 20'h54321;
    deliver(w, "R6 slow");
    read_bits(w, 0, 26);
    chk(cal_active, 1'b1, "R6 cal starts slow");
    repeat (CSLOW - 3) @(negedge clk);
    chk(cal_active, 1'b1, "R6 cal still active near slow end");
    repeat (5) @(negedge clk);
    chk(cal_active, 1'b0, "R6 cal done slow");
    speed_fast = 1'b1;

    // R8: standby partway through a read
    w = 20'hC0DE5;
    deliver(w, "R8");
    read_bits(w, 0, 4);
    sclk_in = 1'b1;
    repeat (30) @(negedge clk);
    chk(standby, 1'b1, "R8 standby entered");
    chk(dout_rdy, 1'b1, "R8 pin high in standby");
    strobe(20'h77777);
    repeat (2) @(negedge clk);
    chk(standby, 1'b1, "R8 strobe ignored in standby");
    sclk_in = 1'b0;
    repeat (5) @(negedge clk);
    chk(standby, 1'b0, "R8 wake on low");
    chk(cal_active, 1'b0, "R8 no cal on plain wake");
    chk(dout_rdy, 1'b1, "R8 idle after wake");

    // R9: standby after exactly 25 edges calibrates on wake
    w = 20'h9ABCD;
    deliver(w, "R9");
    read_bits(w, 0, 24);
    sclk_in = 1'b1;
    repeat (30) @(negedge clk);
    chk(standby, 1'b1, "R9 standby entered");
    sclk_in = 1'b0;
    repeat (5) @(negedge clk);
    chk(standby, 1'b0, "R9 standby left");
    chk(cal_active, 1'b1, "R9 cal on wake");
    repeat (CFAST + 2) @(negedge clk);
    chk(cal_active, 1'b0, "R9 cal done");

    // R1: power-down mid-read
    w = 20'h0000F;
    deliver(w, "R1");
    read_bits(w, 0, 3);
    pdwn_n = 1'b0;
    @(negedge clk);
    chk(dout_rdy, 1'b1, "R1 pin high on power-down");
    pdwn_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(dout_rdy, 1'b1, "R1 no data after power-down");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule